// File: doc/BRIEF.md
# Word/Byte Arithmetic Flag Unit

This block is an arithmetic-logic stage with a flag generator. It works on 16-bit words or on 8-bit bytes. In one clock it takes two operands, an operation code, a width select and the present carry and zero flags. One cycle later it returns the result together with new negative (N), carry (C), overflow (V) and zero (Z) flags.

The arithmetic operations are add, add with carry, subtract, subtract with carry, compare and negate. Subtraction runs as a two's complement addition, and carry holds an inverted borrow: C set means a borrow occurred. Add with carry and subtract with carry chain the zero flag, so that a multi-word result reads as zero only when every part of it was zero.

The logical operations are AND, OR and XOR. Multiply and divide are computed by an external unit. For those two, this block only takes the external result and its overflow indication and applies the flag rules to them.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset, out_valid, result and all four flags are 0. Each accepted input (in_valid=1) gives registered outputs one cycle later, with out_valid=1. When in_valid=0, out_valid falls to 0 and result and the flags keep their values.
- R2: ADD (opcode 0) gives C equal to the carry out of bit 15 in word mode, or out of bit 7 in byte mode (byte_mode=1).
- R3: SUB (opcode 2) and CMP (opcode 4) compute op_a + ~op_b + 1 and output that difference. C is 1 when this addition produces no carry and 0 when it does.
- R4: ADDC (opcode 1) adds c_in as carry-in. SUBC (opcode 3) takes c_in=1 as a borrow, so it computes op_a + ~op_b + (1 - c_in). C follows the rule of R2 or R3 respectively.
- R5: For opcodes 0 to 5, V is 1 exactly when the signed result leaves -8000h..+7FFFh in word mode, or -80h..+7Fh in byte mode.
- R6: NEG (opcode 5) outputs 0 - op_a at the selected width. C is 1 unless the operand is zero.
- R7: AND, OR and XOR (opcodes 6, 7, 8) output the bitwise result with C=0 and V=0, whatever the values of c_in and z_in.
- R8: MUL (opcode 9) and DIV (opcode 10) output ext_result with C=0 and V=ext_ovf. A DIV whose op_b is zero at the selected width always sets V.
- R9: Apart from opcodes 1 and 3, Z is 1 exactly when the result is zero at the selected width. The value of z_in is ignored.
- R10: For ADDC and SUBC, Z is 1 only when z_in is 1 and the current result is zero.
- R11: N equals bit 15 of the result in word mode and bit 7 in byte mode.
- R12: In byte mode only the low 8 bits of each operand count, and bits 15..8 of the result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the operation on this edge |
| opcode | input | 4 | Operation code (0..10) |
| byte_mode | input | 1 | 1 = byte width, 0 = word width |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand, also the divisor for DIV |
| c_in | input | 1 | Present carry flag |
| z_in | input | 1 | Present zero flag |
| ext_result | input | 16 | Result from the external multiply/divide unit |
| ext_ovf | input | 1 | Overflow indication from the external unit |
| out_valid | output | 1 | Registered outputs hold a new result |
| result | output | 16 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / inverted borrow flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the unit with its default word width of 16, which gives a byte width of 8. At these values every overflow boundary (7FFFh+1, 8000h-1, negating 8000h and the byte 7Fh+1) can be written as a literal vector. The same sizes bring within reach byte operands whose upper bytes carry values that must be ignored, and a divisor that is zero only in its low byte. Borrow-chained subtraction and carry-chained addition are run with both values of the incoming zero flag, so that the chained Z rule and the plain Z rule can be told apart.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_NEG  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_MUL  = 4'd9,
    OP_DIV  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_EXT   = 2'd2,
    CLS_NONE  = 2'd3
  } op_class_e;

  typedef struct packed {
    logic n;
    logic c;
    logic v;
    logic z;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         carry_i,
  input  logic         byte_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  localparam int BW = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};

  function automatic logic [W-1:0] narrow(input logic [W-1:0] v, input logic bsel);
    return bsel ? (v & LOW_MASK) : v;
  endfunction

  function automatic logic top_bit(input logic [W-1:0] v, input logic bsel);
    return bsel ? v[BW-1] : v[W-1];
  endfunction

  logic [W-1:0] a_n;
  logic [W-1:0] b_n;
  logic [W:0]   total;
  logic [W-1:0] sum_n;

  always_comb begin
    a_n     = narrow(a_i, byte_i);
    b_n     = narrow(inv_b_i ? ~b_i : b_i, byte_i);
    total   = {1'b0, a_n} + {1'b0, b_n} + {{W{1'b0}}, carry_i};
    sum_n   = narrow(total[W-1:0], byte_i);
    carry_o = byte_i ? total[BW] : total[W];
    ovf_o   = (top_bit(a_n, byte_i) == top_bit(b_n, byte_i)) &&
              (top_bit(sum_n, byte_i) != top_bit(a_n, byte_i));
  end

  assign sum_o = sum_n;

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 16
) (
  input  alu_flag_pkg::alu_op_e op_i,
  input  logic [W-1:0]          a_i,
  input  logic [W-1:0]          b_i,
  input  logic                  byte_i,
  output logic [W-1:0]          res_o
);
  import alu_flag_pkg::*;
  localparam int BW = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};

  logic [W-1:0] raw;

  always_comb begin
    unique case (op_i)
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      default: raw = '0;
    endcase
    res_o = byte_i ? (raw & LOW_MASK) : raw;
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0]                 result_i,
  input  logic                         byte_i,
  input  alu_flag_pkg::op_class_e      cls_i,
  input  logic                         arith_carry_i,
  input  logic                         arith_ovf_i,
  input  logic                         ext_ovf_i,
  input  logic                         div_zero_i,
  input  logic                         chain_z_i,
  input  logic                         z_in_i,
  output alu_flag_pkg::alu_flags_t     flags_o
);
  import alu_flag_pkg::*;
  localparam int BW = W / 2;

  function automatic logic is_zero(input logic [W-1:0] v, input logic bsel);
    return bsel ? (v[BW-1:0] == '0) : (v == '0);
  endfunction

  logic res_zero;

  always_comb begin
    res_zero  = is_zero(result_i, byte_i);
    flags_o.n = byte_i ? result_i[BW-1] : result_i[W-1];
    flags_o.z = chain_z_i ? (z_in_i & res_zero) : res_zero;
    case (cls_i)
      CLS_ARITH: begin
        flags_o.c = arith_carry_i;
        flags_o.v = arith_ovf_i;
      end
      CLS_EXT: begin
        flags_o.c = 1'b0;
        flags_o.v = ext_ovf_i | div_zero_i;
      end
      default: begin
        flags_o.c = 1'b0;
        flags_o.v = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   opcode,
  input  logic         byte_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         c_in,
  input  logic         z_in,
  input  logic [W-1:0] ext_result,
  input  logic         ext_ovf,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_z
);
  import alu_flag_pkg::*;
  localparam int BW = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};

  alu_op_e    op_e;
  op_class_e  op_cls;
  logic       is_sub;
  logic       add_cin;
  logic       neg_op;
  logic [W-1:0] add_a;
  logic [W-1:0] add_sum;
  logic       add_carry;
  logic       add_ovf;
  logic       arith_c;
  logic       div_by_zero;
  logic       z_chain;
  logic [W-1:0] logic_res;
  logic [W-1:0] ext_res_n;
  logic [W-1:0] res_comb;
  alu_flags_t flags_comb;

  assign op_e = alu_op_e'(opcode);

  // operation decode
  always_comb begin
    is_sub  = 1'b0;
    add_cin = 1'b0;
    neg_op  = 1'b0;
    z_chain = 1'b0;
    op_cls  = CLS_NONE;
    case (op_e)
      OP_ADD:  op_cls = CLS_ARITH;
      OP_ADDC: begin op_cls = CLS_ARITH; add_cin = c_in; z_chain = 1'b1; end
      OP_SUB,
      OP_CMP:  begin op_cls = CLS_ARITH; is_sub = 1'b1; add_cin = 1'b1; end
      OP_SUBC: begin op_cls = CLS_ARITH; is_sub = 1'b1; add_cin = ~c_in; z_chain = 1'b1; end
      OP_NEG:  begin op_cls = CLS_ARITH; is_sub = 1'b1; add_cin = 1'b1; neg_op = 1'b1; end
      OP_AND,
      OP_OR,
      OP_XOR:  op_cls = CLS_LOGIC;
      OP_MUL,
      OP_DIV:  op_cls = CLS_EXT;
      default: op_cls = CLS_NONE;
    endcase
  end

  assign add_a = neg_op ? '0 : op_a;

  alu_addsub #(.W(W)) addsub_i (
    .a_i     (add_a),
    .b_i     (neg_op ? op_a : op_b),
    .inv_b_i (is_sub),
    .carry_i (add_cin),
    .byte_i  (byte_mode),
    .sum_o   (add_sum),
    .carry_o (add_carry),
    .ovf_o   (add_ovf)
  );

  alu_logic #(.W(W)) logic_i (
    .op_i   (op_e),
    .a_i    (op_a),
    .b_i    (op_b),
    .byte_i (byte_mode),
    .res_o  (logic_res)
  );

  // subtraction keeps the inverted-borrow convention
  assign arith_c     = is_sub ? ~add_carry : add_carry;
  assign div_by_zero = (op_e == OP_DIV) &&
                       (byte_mode ? (op_b[BW-1:0] == '0) : (op_b == '0));
  assign ext_res_n   = byte_mode ? (ext_result & LOW_MASK) : ext_result;

  always_comb begin
    case (op_cls)
      CLS_ARITH: res_comb = add_sum;
      CLS_LOGIC: res_comb = logic_res;
      CLS_EXT:   res_comb = ext_res_n;
      default:   res_comb = '0;
    endcase
  end

  alu_flags #(.W(W)) flags_i (
    .result_i      (res_comb),
    .byte_i        (byte_mode),
    .cls_i         (op_cls),
    .arith_carry_i (arith_c),
    .arith_ovf_i   (add_ovf),
    .ext_ovf_i     (ext_ovf),
    .div_zero_i    (div_by_zero),
    .chain_z_i     (z_chain),
    .z_in_i        (z_in),
    .flags_o       (flags_comb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_comb;
        flag_n <= flags_comb.n;
        flag_c <= flags_comb.c;
        flag_v <= flags_comb.v;
        flag_z <= flags_comb.z;
      end
    end
  end

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [3:0]   opcode,
  input logic         byte_mode,
  input logic [W-1:0] op_b,
  input logic         z_in,
  input logic         ext_ovf,
  input logic         div_by_zero,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         flag_n,
  input logic         flag_c,
  input logic         flag_v,
  input logic         flag_z
);
  localparam int BW = W / 2;

  // R1: every accepted operation is reported on the next edge
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1: outputs hold while nothing is accepted
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)));

  // R7: logical operations never report carry or overflow
  a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= 4'd6 && opcode <= 4'd8) |=> (!flag_c && !flag_v));

  // R8: a zero divisor always overflows
  a_r8_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd10 &&
     (byte_mode ? (op_b[BW-1:0] == '0) : (op_b == '0))) |=> flag_v);

  // R8: the internal zero-divisor event tracks the opcode
  a_r8_div_event: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> (opcode == 4'd10));

  // R10: chained zero cannot appear without an incoming zero
  a_r10_chain_z: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 4'd1 || opcode == 4'd3) && !z_in) |=> !flag_z);

  // R12: byte results keep the upper byte clear
  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byte_mode) |=> (result[W-1:BW] == '0));

  // R11: N mirrors the sign bit of the selected width
  a_r11_n_msb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flag_n == ($past(byte_mode) ? result[BW-1] : result[W-1])));

  // R9/R10: Z set implies a zero result at the selected width
  a_r9_z_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid) |=> (!flag_z || ($past(byte_mode) ? (result[BW-1:0] == '0) : (result == '0))));

  // R8: external overflow always reaches V
  a_r8_ext_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 4'd9 || opcode == 4'd10) && ext_ovf) |=> (flag_v && !flag_c));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .opcode      (opcode),
  .byte_mode   (byte_mode),
  .op_b        (op_b),
  .z_in        (z_in),
  .ext_ovf     (ext_ovf),
  .div_by_zero (div_by_zero),
  .out_valid   (out_valid),
  .result      (result),
  .flag_n      (flag_n),
  .flag_c      (flag_c),
  .flag_v      (flag_v),
  .flag_z      (flag_z)
);

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;

  typedef struct packed {
    logic [3:0]  op;
    logic        bm;
    logic [15:0] a;
    logic [15:0] b;
    logic        ci;
    logic        zi;
    logic [15:0] er;
    logic        eo;
    logic [15:0] xr;
    logic [3:0]  xf;   // {N, C, V, Z}
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h8000, 4'b1010}, // R5 R11
    '{4'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0101}, // R2 R9
    '{4'd0, 1'b1, 16'h12F0, 16'h3410, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0101}, // R2 R12
    '{4'd2, 1'b0, 16'h0005, 16'h0003, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0002, 4'b0000}, // R3
    '{4'd2, 1'b0, 16'h0003, 16'h0005, 1'b0, 1'b0, 16'h0000, 1'b0, 16'hFFFE, 4'b1100}, // R3
    '{4'd4, 1'b0, 16'h8000, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h7FFF, 4'b0010}, // R3 R5
    '{4'd3, 1'b0, 16'h0005, 16'h0003, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0001, 4'b0000}, // R4
    '{4'd3, 1'b0, 16'h0004, 16'h0003, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 4'b0001}, // R10
    '{4'd3, 1'b0, 16'h0004, 16'h0003, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0000}, // R10
    '{4'd1, 1'b0, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0100}, // R4 R10
    '{4'd1, 1'b1, 16'h007F, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0080, 4'b1010}, // R4 R5
    '{4'd5, 1'b0, 16'h8000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h8000, 4'b1110}, // R6 R5
    '{4'd5, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0001}, // R6
    '{4'd5, 1'b1, 16'hAB01, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h00FF, 4'b1100}, // R6 R12
    '{4'd6, 1'b0, 16'hF0F0, 16'h0FF0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h00F0, 4'b0000}, // R7
    '{4'd7, 1'b0, 16'h8000, 16'h0001, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h8001, 4'b1000}, // R7 R11
    '{4'd8, 1'b0, 16'h5A5A, 16'h5A5A, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0001}, // R7 R9
    '{4'd8, 1'b1, 16'hFF00, 16'h00FF, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h00FF, 4'b1000}, // R12
    '{4'd9, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h1234, 1'b1, 16'h1234, 4'b0010}, // R8
    '{4'd9, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0001}, // R8 R9
    '{4'd10,1'b0, 16'h0009, 16'h0000, 1'b0, 1'b0, 16'h0005, 1'b0, 16'h0005, 4'b0010}, // R8
    '{4'd10,1'b1, 16'h0009, 16'h0100, 1'b0, 1'b0, 16'h0003, 1'b0, 16'h0003, 4'b0010}, // R8 R12
    '{4'd10,1'b0, 16'h0009, 16'h0003, 1'b0, 1'b0, 16'h8000, 1'b0, 16'h8000, 4'b1000}, // R8 R11
    '{4'd0, 1'b1, 16'hFF80, 16'h0080, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 4'b0111}  // R5 R12
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        c_in = 1'b0;
  logic        z_in = 1'b0;
  logic [15:0] ext_result = '0;
  logic        ext_ovf = 1'b0;
  logic        out_valid;
  logic [15:0] result;
  logic        flag_n, flag_c, flag_v, flag_z;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  alu_flag_unit #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .byte_mode(byte_mode), .op_a(op_a), .op_b(op_b), .c_in(c_in), .z_in(z_in),
    .ext_result(ext_result), .ext_ovf(ext_ovf), .out_valid(out_valid),
    .result(result), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
    .flag_z(flag_z)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check_outputs(input string req, input logic v,
                               input logic [15:0] r, input logic [3:0] f);
    check(req, "out_valid", {31'd0, out_valid}, {31'd0, v});
    check(req, "result", {16'd0, result}, {16'd0, r});
    check(req, "flags NCVZ", {28'd0, flag_n, flag_c, flag_v, flag_z}, {28'd0, f});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_outputs("R1 reset", 1'b0, 16'h0000, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 idle", 1'b0, 16'h0000, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      in_valid   = 1'b1;
      opcode     = VECS[i].op;
      byte_mode  = VECS[i].bm;
      op_a       = VECS[i].a;
      op_b       = VECS[i].b;
      c_in       = VECS[i].ci;
      z_in       = VECS[i].zi;
      ext_result = VECS[i].er;
      ext_ovf    = VECS[i].eo;
      @(negedge clk);
      check_outputs($sformatf("vector %0d", i), 1'b1, VECS[i].xr, VECS[i].xf);
    end

    // R1: hold while in_valid is low, new inputs must not leak through
    in_valid = 1'b0;
    opcode   = 4'd7;
    op_a     = 16'hFFFF;
    op_b     = 16'h1234;
    @(negedge clk);
    check_outputs("R1 hold", 1'b0, 16'h0000, 4'b0111);

    // R12: byte add with upper bytes set and no carry
    in_valid  = 1'b1;
    opcode    = 4'd0;
    byte_mode = 1'b1;
    op_a      = 16'hAA11;
    op_b      = 16'h5522;
    @(negedge clk);
    check_outputs("R12 byte add", 1'b1, 16'h0033, 4'b0000);

    // R3: compare of equal values gives zero, no borrow
    opcode    = 4'd4;
    byte_mode = 1'b0;
    op_a      = 16'h1234;
    op_b      = 16'h1234;
    @(negedge clk);
    check_outputs("R3 equal compare", 1'b1, 16'h0000, 4'b0001);

    // R1: reset in mid-run clears the outputs
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    check_outputs("R1 mid reset", 1'b0, 16'h0000, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule